// File: doc/BRIEF.md
# Period-Match Watchdog Limit Timer

This block is an 8-bit up-counting limit timer meant to guard an external output stage. It advances on a system-rate clock enable, optionally divided by a selectable prescaler, and compares its running count with a programmable period value. When the count has reached the period and another prescaled tick arrives, the count returns to zero. In the same edge the block raises a single-cycle shutdown pulse, which can be wired straight to the fast shutdown input of the stage it protects.

The same match events feed a programmable postscaler. When the postscaler overflows it sets a sticky interrupt flag. The interrupt output is that flag gated by an enable bit. A simple write port gives access to the count, period and control registers, and all three are always visible on read-back outputs. A sleep input freezes the timer without losing its state.

Top module: `limit_timer`

## Requirements
- R1: After reset the count reads 00h, the period reads FFh, the control register reads 00h, and shutdown, irq_flag and irq are all low.
- R2: Control bits [2:1] select the prescale ratio. Codes 0, 1, 2 and 3 give one count step per 1, 4, 16 and 64 enabled ticks.
- R3: A prescaled tick adds one to the count. If the count already equals the period when that tick arrives, the count becomes 00h instead, and shutdown is high for exactly the following cycle.
- R4: Control bits [6:3] hold a value N. irq_flag sets at the (N+1)-th match counted since the postscaler was last cleared.
- R5: A write to the count or to the control register clears both the prescaler and the postscaler. A count write takes precedence over a tick in the same cycle.
- R6: Control bit [0] is the run bit. While it is 0, the count and the prescaler hold their values.
- R7: irq_flag stays set until it is cleared. irq equals irq_flag ANDed with control bit [7].
- R8: A high flag_clr clears irq_flag. If a postscaler overflow happens in the same cycle, the flag stays set.
- R9: While sleep is high, the prescaler, the count and the postscaler hold their values.
- R10: wr_sel selects the register a write goes to: 0 is the count, 1 is the period, 2 is the control register. A write with wr_sel 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Instruction-rate clock enable that drives the timer |
| sleep | input | 1 | Freezes the prescaler, count and postscaler |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 count, 1 period, 2 control, 3 none |
| wr_data | input | 8 | Write data |
| flag_clr | input | 1 | Clears the interrupt flag |
| count_q | output | 8 | Current count |
| period_q | output | 8 | Period register |
| ctrl_q | output | 8 | Control register |
| shutdown | output | 1 | One-cycle match pulse for the protected stage |
| irq_flag | output | 1 | Sticky postscaler overflow flag |
| irq | output | 1 | Flag gated by the interrupt enable |

## Verification
Most wrong internal states show up quickly at the ports. A wrong count or a missed wrap appears on count_q at the next prescaled tick, and a shutdown pulse that is too long or too early appears in the very next cycle. A prescaler or postscaler that is corrupted or not cleared stays hidden until the next count step or the next interrupt. With ratio 64 and postscale 16, that can take up to a thousand ticks. For this reason the bench compares every output on every cycle against a reference model, and it runs short periods so that matches happen often.

// File: rtl/lt_pkg.sv
package lt_pkg;
  localparam int CNT_W  = 8;
  localparam int PSEL_W = 2;
  localparam int POST_W = 4;

  typedef enum logic [1:0] {
    SEL_COUNT  = 2'd0,
    SEL_PERIOD = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_NONE   = 2'd3
  } wsel_e;

  typedef struct packed {
    logic              irq_en;
    logic [POST_W-1:0] post;
    logic [PSEL_W-1:0] pre;
    logic              run;
  } ctrl_t;
endpackage

// File: rtl/lt_prescaler.sv
module lt_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [SEL_W-1:0] sel,
  output logic             term
);
  localparam int MAX_SH = 2 * ((1 << SEL_W) - 1);
  localparam int PW     = (MAX_SH < 1) ? 1 : MAX_SH;

  function automatic logic [PW-1:0] div_limit(input logic [SEL_W-1:0] s);
    logic [PW-1:0] ones;
    ones = '1;
    return ones >> (PW - 2 * int'(s));
  endfunction

  logic [PW-1:0] cnt;
  logic [PW-1:0] limit;

  assign limit = div_limit(sel);
  assign term  = step && (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (term)   cnt <= '0;
    else if (step)   cnt <= cnt + 1'b1;
  end

  a_r2_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !step) |=> $stable(cnt));
  a_r5_pre_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
endmodule

// File: rtl/lt_counter.sv
module lt_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  input  logic [W-1:0] period,
  output logic [W-1:0] count,
  output logic         match_evt,
  output logic         match_q
);
  function automatic logic [W-1:0] next_count(input logic [W-1:0] c,
                                              input logic [W-1:0] p);
    return (c == p) ? '0 : c + 1'b1;
  endfunction

  assign match_evt = inc && !load && (count == period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      match_q <= 1'b0;
    end else begin
      match_q <= match_evt;
      if (load)     count <= load_val;
      else if (inc) count <= next_count(count, period);
    end
  end

  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> (count == '0) && match_q);
  a_r3_pulse_src: assert property (@(posedge clk) disable iff (!rst_n)
    !match_evt |=> !match_q);
  a_r5_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(load_val)));
endmodule

// File: rtl/lt_postscaler.sv
module lt_postscaler #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         evt,
  input  logic [W-1:0] limit,
  output logic         ovf
);
  logic [W-1:0] cnt;

  assign ovf = evt && !clr && (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (ovf)   cnt <= '0;
    else if (evt)   cnt <= cnt + 1'b1;
  end

  a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt && !clr) |=> $stable(cnt));
  a_r5_post_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
endmodule

// File: rtl/limit_timer.sv
module limit_timer
  import lt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             sleep,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] period_q,
  output logic [CNT_W-1:0] ctrl_q,
  output logic             shutdown,
  output logic             irq_flag,
  output logic             irq
);
  ctrl_t      ctrl;
  logic       wr_count, wr_period, wr_ctrl;
  logic       clear_scalers;
  logic       step;
  logic       pre_term;
  logic       match_evt;
  logic       post_ovf;

  assign wr_count  = wr_en && (wsel_e'(wr_sel) == SEL_COUNT);
  assign wr_period = wr_en && (wsel_e'(wr_sel) == SEL_PERIOD);
  assign wr_ctrl   = wr_en && (wsel_e'(wr_sel) == SEL_CTRL);

  assign clear_scalers = wr_count || wr_ctrl;
  assign step          = tick_en && ctrl.run && !sleep && !clear_scalers;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '1;
      ctrl     <= '0;
    end else begin
      if (wr_period) period_q <= wr_data;
      if (wr_ctrl)   ctrl     <= ctrl_t'(wr_data);
    end
  end

  lt_prescaler #(.SEL_W(PSEL_W)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clear_scalers),
    .step (step),
    .sel  (ctrl.pre),
    .term (pre_term)
  );

  lt_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_count),
    .load_val (wr_data),
    .inc      (pre_term),
    .period   (period_q),
    .count    (count_q),
    .match_evt(match_evt),
    .match_q  (shutdown)
  );

  lt_postscaler #(.W(POST_W)) u_post (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clear_scalers),
    .evt  (match_evt),
    .limit(ctrl.post),
    .ovf  (post_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        irq_flag <= 1'b0;
    else if (post_ovf) irq_flag <= 1'b1;
    else if (flag_clr) irq_flag <= 1'b0;
  end

  assign ctrl_q = ctrl;
  assign irq    = irq_flag && ctrl.irq_en;

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !flag_clr) |=> irq_flag);
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    post_ovf |=> irq_flag);
  a_r9_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !wr_en) |=> $stable(count_q) && !shutdown);
  a_r6_run_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run && !wr_en) |=> $stable(count_q));
  a_r10_no_target: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd3) |=> $stable(period_q) && $stable(ctrl_q));
endmodule

// File: tb/tb_limit_timer.sv
`timescale 1ns/1ps
module tb_limit_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0, sleep = 1'b0, wr_en = 1'b0, flag_clr = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] count_q, period_q, ctrl_q;
  logic       shutdown, irq_flag, irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  limit_timer dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .sleep(sleep),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .flag_clr(flag_clr),
    .count_q(count_q), .period_q(period_q), .ctrl_q(ctrl_q),
    .shutdown(shutdown), .irq_flag(irq_flag), .irq(irq)
  );

  function automatic int ratio(input logic [1:0] code);
    case (code)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 16;
      default: return 64;
    endcase
  endfunction

  // reference model
  int   m_pre, m_post;
  logic [7:0] m_cnt, m_per, m_ctl;
  logic m_sd, m_flag;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_post = 0; m_cnt = 8'h00; m_per = 8'hFF; m_ctl = 8'h00;
      m_sd = 1'b0; m_flag = 1'b0;
    end else begin
      bit wc, wp, wk, adv, stepc, hit, ovf;
      wc = wr_en && wr_sel == 2'd0;
      wp = wr_en && wr_sel == 2'd1;
      wk = wr_en && wr_sel == 2'd2;
      adv = tick_en && m_ctl[0] && !sleep && !wc && !wk;
      stepc = adv && (m_pre + 1 == ratio(m_ctl[2:1]));
      hit = stepc && (m_cnt == m_per);
      ovf = hit && (m_post == int'(m_ctl[6:3]));
      if (wc || wk) m_pre = 0;
      else if (adv) m_pre = stepc ? 0 : m_pre + 1;
      if (wc || wk) m_post = 0;
      else if (hit) m_post = ovf ? 0 : m_post + 1;
      if (wc) m_cnt = wr_data;
      else if (stepc) m_cnt = hit ? 8'h00 : m_cnt + 8'd1;
      if (wp) m_per = wr_data;
      if (wk) m_ctl = wr_data;
      m_sd = hit;
      if (ovf) m_flag = 1'b1;
      else if (flag_clr) m_flag = 1'b0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 count", count_q, m_cnt);
      chk("R3 shutdown", shutdown, m_sd);
      chk("R4 irq_flag", irq_flag, m_flag);
      chk("R7 irq", irq, m_flag && m_ctl[7]);
      chk("R10 period", period_q, m_per);
      chk("R10 ctrl", ctrl_q, m_ctl);
    end
  end

  task automatic step(input bit we, input logic [1:0] sel, input logic [7:0] d,
                      input bit tk, input bit sl, input bit cl);
    wr_en = we; wr_sel = sel; wr_data = d; tick_en = tk; sleep = sl; flag_clr = cl;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(0, 2'd0, 8'd0, 1, 0, 0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", count_q, 8'h00);
    chk("R1 period", period_q, 8'hFF);
    chk("R1 ctrl", ctrl_q, 8'h00);
    chk("R1 shutdown", shutdown, 0);
    chk("R1 irq", irq, 0);

    // R2 divide by 4: eight ticks give two steps
    step(1, 2'd0, 8'd0, 0, 0, 0);
    step(1, 2'd2, 8'h03, 0, 0, 0);
    ticks(8);
    chk("R2 div4 count", count_q, 2);

    // R5 count write mid-prescale, same-cycle tick loses
    ticks(2);
    step(1, 2'd0, 8'd5, 1, 0, 0);
    chk("R5 write wins", count_q, 5);
    ticks(3);
    chk("R5 prescaler cleared", count_q, 5);
    ticks(1);
    chk("R5 step after clear", count_q, 6);

    // R10 no-target write
    step(1, 2'd3, 8'h55, 0, 0, 0);
    chk("R10 count kept", count_q, 6);
    chk("R10 period kept", period_q, 8'hFF);

    // R3 wrap and one-cycle shutdown: period 2, div 1
    step(1, 2'd1, 8'd2, 0, 0, 0);
    step(1, 2'd0, 8'd0, 0, 0, 0);
    step(1, 2'd2, 8'h01, 0, 0, 0);
    ticks(3);
    chk("R3 wrap count", count_q, 0);
    chk("R3 shutdown high", shutdown, 1);
    ticks(1);
    chk("R3 shutdown low", shutdown, 0);
    chk("R3 count after wrap", count_q, 1);

    // R9 sleep freezes
    for (int i = 0; i < 5; i++) step(0, 2'd0, 8'd0, 1, 1, 0);
    chk("R9 sleep hold", count_q, 1);

    // R4 postscale 3: flag at 4th match with period 1
    step(1, 2'd1, 8'd1, 0, 0, 1);
    step(1, 2'd0, 8'd0, 0, 0, 1);
    step(1, 2'd2, 8'd153, 0, 0, 0);
    ticks(7);
    chk("R4 before 4th match", irq_flag, 0);
    ticks(1);
    chk("R4 at 4th match", irq_flag, 1);
    chk("R7 irq enabled", irq, 1);

    // R7 enable off masks irq; R6 run off holds count
    step(1, 2'd2, 8'h18, 0, 0, 0);
    ticks(4);
    chk("R7 irq masked", irq, 0);
    chk("R7 flag sticky", irq_flag, 1);
    chk("R6 run off hold", count_q, 0);

    // R8 set wins over clear: period 0, match every tick
    step(1, 2'd1, 8'd0, 0, 0, 0);
    step(1, 2'd2, 8'h81, 0, 0, 1);
    for (int i = 0; i < 3; i++) step(0, 2'd0, 8'd0, 1, 0, 1);
    chk("R8 set wins", irq_flag, 1);
    step(1, 2'd2, 8'h80, 0, 0, 0);
    step(0, 2'd0, 8'd0, 0, 0, 1);
    chk("R8 clear", irq_flag, 0);

    // random phase, checked by the model every cycle
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [7:0] d;
      r = $urandom_range(0, 99);
      d = 8'($urandom);
      if (r < 4)       step(1, 2'd0, d & 8'h07, $urandom_range(0,1), 0, 0);
      else if (r < 7)  step(1, 2'd1, d & 8'h07, $urandom_range(0,1), 0, 0);
      else if (r < 9)  step(1, 2'd2, {d[7:3], ($urandom_range(0,3) == 0) ? d[2:1] : 2'b00,
                                      ($urandom_range(0,5) != 0)},
                            $urandom_range(0,1), 0, 0);
      else if (r < 10) step(1, 2'd3, d, 1, 0, 0);
      else             step(0, 2'd0, d, $urandom_range(0,3) != 0,
                            $urandom_range(0,15) == 0, $urandom_range(0,19) == 0);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule